// File: doc/BRIEF.md
# Operand Address Generator

This block forms the effective memory address of an indirect, indexed or post-increment operand for a microcontroller datapath. The datapath has 20-bit registers and runs both a legacy 16-bit instruction format and an extended 20-bit format. The block takes four inputs from the decode stage: the value of the base register, a signed offset, an operand-size code and a format flag. It returns the address. If the operand post-increments its base register, the block also returns the updated register value and a one-cycle write enable for the register file.

For legacy instructions the offset is signed at bit 15. When the base lies in the low 64 KiB, the sum wraps inside 16 bits, so legacy code keeps working. Extended instructions, and legacy instructions with a base at or above 0x10000, use the full 20-bit sum. If no base register is selected, the offset alone is the absolute address. A post-incremented stack pointer is kept at an even value.

A parameter selects whether the results pass through a register stage (one cycle of latency, the default) or leave the block combinationally.

Top module: `opnd_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `addr_vld`, `eff_addr`, `wb_en` and `wb_data` to zero.
- R2: With the default registered stage, outputs reflect the inputs sampled at the previous rising edge. `addr_vld` is high in exactly the cycle after `op_vld` was sampled high.
- R3: For a legacy-format operand (`ext_fmt`=0), the offset is the 16-bit value `offset[15:0]`, sign-extended from bit 15. Bits 19:16 of `offset` have no effect on the address.
- R4: For an extended-format operand (`ext_fmt`=1), the whole 20-bit `offset` is a signed value. The address is (base + offset) modulo 2^20.
- R5: For a legacy-format operand with `base_en`=1 and a base value below 0x10000, the address is the sum truncated to 16 bits, so bits 19:16 are zero.
- R6: For a legacy-format operand with a base value of 0x10000 or above, the address is the full 20-bit sum modulo 2^20.
- R7: With `base_en`=0, the address equals `offset` exactly, whatever the format, and `base_val` has no effect.
- R8: For a post-increment operand, `wb_data` is (base + increment) modulo 2^20. The increment is set by `size_code`: 0 (byte) gives 1, 1 (word) gives 2, and 2 (20-bit) or 3 (32-bit) gives 4.
- R9: When `base_is_sp`=1 and the incremented value is odd, `wb_data` is that value plus one, modulo 2^20.
- R10: `wb_en` is high only in the output cycle of an operand that had `op_vld`, `post_inc` and `base_en` all set. In every other cycle `wb_en` is low and `wb_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 1 | An operand is presented this cycle |
| base_en | input | 1 | A base register is used (0: absolute offset) |
| base_val | input | 20 | Current value of the base register |
| base_is_sp | input | 1 | Base register is the stack pointer |
| offset | input | 20 | Signed index / absolute address |
| size_code | input | 2 | Operand size: 0 byte, 1 word, 2 20-bit, 3 32-bit |
| ext_fmt | input | 1 | 1: extended 20-bit format, 0: legacy format |
| post_inc | input | 1 | Operand post-increments its base register |
| addr_vld | output | 1 | `eff_addr` is valid |
| eff_addr | output | 20 | Effective address |
| wb_en | output | 1 | Base register write-back enable |
| wb_data | output | 20 | Post-incremented base register value |

## Verification
Random operands are split between bases below and above 0x10000 and between the two formats. This separates the 16-bit wrap from the full 20-bit sum. Random offsets with garbage in bits 19:16 show whether the legacy sign extension really ignores those bits.

Directed cases cover a set of boundaries:
- A sum that crosses 0xFFFF with a low base.
- The same sum with a high base.
- Extended wrap through 0xFFFFF.
- Negative legacy offsets.
- Absolute addressing with a nonzero base.
- An odd stack pointer after a byte and after a word increment.
- Idle cycles after a post-increment, which show that the write enable lasts for one cycle only.

// File: rtl/addr_gen_pkg.sv
`timescale 1ns/1ps
// Package: shared operand-size encoding and the size-to-byte-count mapping
// for the operand address generator.
package addr_gen_pkg;

    // Operand size code as presented by the decode stage.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_ADDR = 2'd2,
        SZ_LONG = 2'd3
    } opsize_e;

    // Number of bytes an operand of the given size occupies in memory.
    function automatic logic [2:0] size_bytes(input opsize_e sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/addr_offset_ext.sv
`timescale 1ns/1ps
// addr_offset_ext
// Widens the signed operand offset to the full address width. Legacy format
// takes only the low LW bits and sign-extends from bit LW-1. Extended format
// takes all AW bits, which are already signed at bit AW-1.
// Assumes AW > LW.
module addr_offset_ext #(
    parameter int AW = 20,
    parameter int LW = 16
) (
    input  logic [AW-1:0] offset,
    input  logic          ext_fmt,
    output logic [AW-1:0] off_sext
);
    localparam int HW = AW - LW;

    logic [AW-1:0] legacy_ext;

    // Sign-extend the low legacy field.
    always_comb begin
        legacy_ext = {{HW{offset[LW-1]}}, offset[LW-1:0]};
    end

    // Pick the extension that matches the instruction format.
    always_comb begin
        off_sext = ext_fmt ? offset : legacy_ext;
    end
endmodule

// File: rtl/addr_index_sum.sv
`timescale 1ns/1ps
// addr_index_sum
// Adds the sign-extended offset to the base register and applies the
// legacy-compatibility wrap. A legacy-format operand whose base lies below
// 2^LW keeps only LW bits of the sum. When no base is selected, the raw
// offset is the absolute address.
// Assumes AW > LW. The sum is modulo 2^AW.
module addr_index_sum #(
    parameter int AW = 20,
    parameter int LW = 16
) (
    input  logic          base_en,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] off_raw,
    input  logic [AW-1:0] off_sext,
    input  logic          ext_fmt,
    output logic [AW-1:0] addr
);
    localparam int HW = AW - LW;

    logic [AW-1:0] full_sum;
    logic          base_low;
    logic          wrap16;

    // Full-width index sum, carry out of AW discarded.
    always_comb begin
        full_sum = base_val + off_sext;
    end

    // Legacy wrap applies to legacy format with a base in the low window.
    always_comb begin
        base_low = (base_val[AW-1:LW] == '0);
        wrap16   = !ext_fmt && base_low;
    end

    // Select absolute, wrapped or full address.
    always_comb begin
        if (!base_en)
            addr = off_raw;
        else if (wrap16)
            addr = {{HW{1'b0}}, full_sum[LW-1:0]};
        else
            addr = full_sum;
    end
endmodule

// File: rtl/addr_postinc_calc.sv
`timescale 1ns/1ps
// addr_postinc_calc
// Computes the post-increment write-back value for the base register:
// old value plus the operand byte count, modulo 2^AW. When the base is the
// stack pointer, an odd result is bumped to the next even value.
// Assumes AW > 3.
module addr_postinc_calc
    import addr_gen_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [AW-1:0] base_val,
    input  opsize_e       size,
    input  logic          is_sp,
    output logic [AW-1:0] next_val
);
    localparam int IW = 3;

    logic [AW-1:0] step;
    logic [AW-1:0] raw_next;

    // Byte count widened to the address width.
    always_comb begin
        step = {{(AW-IW){1'b0}}, size_bytes(size)};
    end

    // Plain increment.
    always_comb begin
        raw_next = base_val + step;
    end

    // Keep the stack pointer word aligned.
    always_comb begin
        if (is_sp && raw_next[0])
            next_val = raw_next + {{(AW-1){1'b0}}, 1'b1};
        else
            next_val = raw_next;
    end
endmodule

// File: rtl/addr_out_stage.sv
`timescale 1ns/1ps
// addr_out_stage
// Optional output register. With REG_OUT=1, every result is flopped and
// cleared by the synchronous active-low reset. With REG_OUT=0, results pass
// straight through and clk/rst_n are not used.
module addr_out_stage #(
    parameter int AW      = 20,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_d,
    input  logic [AW-1:0] addr_d,
    input  logic          wb_en_d,
    input  logic [AW-1:0] wb_data_d,
    output logic          vld_q,
    output logic [AW-1:0] addr_q,
    output logic          wb_en_q,
    output logic [AW-1:0] wb_data_q
);
    generate
        if (REG_OUT) begin : g_reg
            // Capture the results or clear them on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q     <= 1'b0;
                    addr_q    <= '0;
                    wb_en_q   <= 1'b0;
                    wb_data_q <= '0;
                end else begin
                    vld_q     <= vld_d;
                    addr_q    <= addr_d;
                    wb_en_q   <= wb_en_d;
                    wb_data_q <= wb_data_d;
                end
            end
        end else begin : g_comb
            // Pass the results through without delay.
            always_comb begin
                vld_q     = vld_d;
                addr_q    = addr_d;
                wb_en_q   = wb_en_d;
                wb_data_q = wb_data_d;
            end
        end
    endgenerate
endmodule

// File: rtl/opnd_addr_gen.sv
`timescale 1ns/1ps
// opnd_addr_gen
// Effective-address and post-increment unit for memory operands. The path
// is offset extension, then index sum with legacy wrap, in parallel with the
// write-back increment, then an optional output register. When no operand
// is valid, the address output is zero. The write-back value is zero
// whenever the write enable is low.
// Assumes the register file applies the write-back in the cycle wb_en is high.
module opnd_addr_gen
    import addr_gen_pkg::*;
#(
    parameter int AW      = 20,
    parameter int LW      = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_vld,
    input  logic          base_en,
    input  logic [AW-1:0] base_val,
    input  logic          base_is_sp,
    input  logic [AW-1:0] offset,
    input  logic [1:0]    size_code,
    input  logic          ext_fmt,
    input  logic          post_inc,
    output logic          addr_vld,
    output logic [AW-1:0] eff_addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_data
);
    logic [AW-1:0] off_sext;
    logic [AW-1:0] sum_addr;
    logic [AW-1:0] inc_val;
    logic          wb_req;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] wb_d;
    opsize_e       size;

    // Map the raw size code onto the enumerated type.
    always_comb begin
        size = opsize_e'(size_code);
    end

    addr_offset_ext #(.AW(AW), .LW(LW)) u_ext (
        .offset   (offset),
        .ext_fmt  (ext_fmt),
        .off_sext (off_sext)
    );

    addr_index_sum #(.AW(AW), .LW(LW)) u_sum (
        .base_en  (base_en),
        .base_val (base_val),
        .off_raw  (offset),
        .off_sext (off_sext),
        .ext_fmt  (ext_fmt),
        .addr     (sum_addr)
    );

    addr_postinc_calc #(.AW(AW)) u_inc (
        .base_val (base_val),
        .size     (size),
        .is_sp    (base_is_sp),
        .next_val (inc_val)
    );

    // Qualify the results with operand validity and write-back mode.
    always_comb begin
        wb_req = op_vld && post_inc && base_en;
        addr_d = op_vld ? sum_addr : '0;
        wb_d   = wb_req ? inc_val : '0;
    end

    addr_out_stage #(.AW(AW), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_d     (op_vld),
        .addr_d    (addr_d),
        .wb_en_d   (wb_req),
        .wb_data_d (wb_d),
        .vld_q     (addr_vld),
        .addr_q    (eff_addr),
        .wb_en_q   (wb_en),
        .wb_data_q (wb_data)
    );
endmodule

// File: rtl/addr_gen_checker.sv
`timescale 1ns/1ps
// addr_gen_checker
// Temporal checks on the ports of opnd_addr_gen, attached by bind.
// Covers only the registered variant, where each output relates to the
// inputs of the previous cycle.
module addr_gen_checker #(
    parameter int AW      = 20,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_vld,
    input logic          base_en,
    input logic [AW-1:0] base_val,
    input logic          base_is_sp,
    input logic [AW-1:0] offset,
    input logic          ext_fmt,
    input logic          post_inc,
    input logic          addr_vld,
    input logic [AW-1:0] eff_addr,
    input logic          wb_en,
    input logic [AW-1:0] wb_data
);
    localparam logic [AW-1:0] LOW_LIMIT = AW'(20'h10000);

    generate
        if (REG_OUT) begin : g_chk
            // R2: valid follows the operand request by one cycle
            assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
                addr_vld |-> $past(op_vld));

            // R5: legacy low-window operands never reach above 16 bits
            assert_legacy_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_vld && !$past(ext_fmt) && $past(base_en) && ($past(base_val) < LOW_LIMIT))
                |-> (eff_addr[AW-1:16] == '0));

            // R7: absolute addressing returns the offset unchanged
            assert_absolute_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (addr_vld && !$past(base_en)) |-> (eff_addr == $past(offset)));

            // R9: a written-back stack pointer is even
            assert_sp_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (wb_en && $past(base_is_sp)) |-> !wb_data[0]);

            // R10: write-back only for a valid post-increment with a base
            assert_wb_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
                wb_en |-> $past(op_vld && post_inc && base_en));

            // R10: write-back data is zero whenever the enable is low
            assert_wb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !wb_en |-> (wb_data == '0));
        end
    endgenerate
endmodule

bind opnd_addr_gen addr_gen_checker #(.AW(AW), .REG_OUT(REG_OUT)) i_addr_gen_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_vld     (op_vld),
    .base_en    (base_en),
    .base_val   (base_val),
    .base_is_sp (base_is_sp),
    .offset     (offset),
    .ext_fmt    (ext_fmt),
    .post_inc   (post_inc),
    .addr_vld   (addr_vld),
    .eff_addr   (eff_addr),
    .wb_en      (wb_en),
    .wb_data    (wb_data)
);

// File: tb/test_opnd_addr_gen.sv
`timescale 1ns/1ps
module test_opnd_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic        base_en = 1'b0;
    logic [19:0] base_val = '0;
    logic        base_is_sp = 1'b0;
    logic [19:0] offset = '0;
    logic [1:0]  size_code = '0;
    logic        ext_fmt = 1'b0;
    logic        post_inc = 1'b0;
    logic        addr_vld;
    logic [19:0] eff_addr;
    logic        wb_en;
    logic [19:0] wb_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    opnd_addr_gen i_opnd_addr_gen (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .base_en(base_en),
        .base_val(base_val), .base_is_sp(base_is_sp), .offset(offset),
        .size_code(size_code), .ext_fmt(ext_fmt), .post_inc(post_inc),
        .addr_vld(addr_vld), .eff_addr(eff_addr), .wb_en(wb_en), .wb_data(wb_data)
    );

    // Reference address, from the requirements.
    function automatic logic [19:0] exp_addr(logic ben, logic [19:0] b, logic [19:0] o, logic ext);
        logic [19:0] so;
        logic [19:0] s;
        if (!ben) return o;
        so = ext ? o : {{4{o[15]}}, o[15:0]};
        s  = b + so;
        if (!ext && b < 20'h10000) s = {4'h0, s[15:0]};
        return s;
    endfunction

    // Reference write-back value, from the requirements.
    function automatic logic [19:0] exp_wb(logic [19:0] b, logic [1:0] sz, logic sp);
        logic [19:0] n;
        n = b + ((sz == 2'd0) ? 20'd1 : (sz == 2'd1) ? 20'd2 : 20'd4);
        if (sp && n[0]) n = n + 20'd1;
        return n;
    endfunction

    task automatic check(string req, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one operand, check its outputs one cycle later, then go idle.
    task automatic run_op(string req, logic ben, logic [19:0] b, logic sp, logic [19:0] o,
                          logic [1:0] sz, logic ext, logic pi);
        logic [19:0] ea;
        logic [19:0] ew;
        logic        ee;
        @(negedge clk);
        op_vld = 1'b1; base_en = ben; base_val = b; base_is_sp = sp;
        offset = o; size_code = sz; ext_fmt = ext; post_inc = pi;
        ea = exp_addr(ben, b, o, ext);
        ee = pi && ben;
        ew = ee ? exp_wb(b, sz, sp) : 20'h0;
        @(negedge clk);
        check({req, " R2 addr_vld"}, {19'h0, addr_vld}, 20'h1);
        check({req, " addr"}, eff_addr, ea);
        check({req, " R10 wb_en"}, {19'h0, wb_en}, {19'h0, ee});
        check({req, " wb_data"}, wb_data, ew);
        op_vld = 1'b0;
        base_val = $urandom;
    endtask

    task automatic check_idle(string req);
        @(negedge clk);
        check({req, " addr_vld idle"}, {19'h0, addr_vld}, 20'h0);
        check({req, " wb_en idle"}, {19'h0, wb_en}, 20'h0);
        check({req, " wb_data idle"}, wb_data, 20'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        // R1: reset clears the outputs even with an operand presented
        op_vld = 1'b1; base_en = 1'b1; post_inc = 1'b1; base_val = 20'h12345;
        repeat (3) @(negedge clk);
        check("R1 addr_vld", {19'h0, addr_vld}, 20'h0);
        check("R1 eff_addr", eff_addr, 20'h0);
        check("R1 wb_en", {19'h0, wb_en}, 20'h0);
        check("R1 wb_data", wb_data, 20'h0);
        op_vld = 1'b0; post_inc = 1'b0;
        rst_n = 1'b1;
        check_idle("R2 after reset");

        // R5: legacy low base wraps at 16 bits
        run_op("R5 wrap", 1'b1, 20'h0FFF0, 1'b0, 20'h00020, 2'd1, 1'b0, 1'b0);
        // R6: legacy high base keeps the carry
        run_op("R6 high base", 1'b1, 20'h1FFF0, 1'b0, 20'h00020, 2'd1, 1'b0, 1'b0);
        // R3: negative legacy offset, upper offset bits ignored
        run_op("R3 neg offset", 1'b1, 20'h20010, 1'b0, 20'hA8000, 2'd1, 1'b0, 1'b0);
        run_op("R3 upper ignored", 1'b1, 20'h01000, 1'b0, 20'hF0004, 2'd0, 1'b0, 1'b0);
        // R4: extended format wraps at 2^20
        run_op("R4 ext wrap", 1'b1, 20'hFFFFF, 1'b0, 20'h00001, 2'd2, 1'b1, 1'b0);
        run_op("R4 ext neg", 1'b1, 20'h00010, 1'b0, 20'hFFFE0, 2'd2, 1'b1, 1'b0);
        // R7: absolute address ignores the base
        run_op("R7 absolute", 1'b0, 20'h1ABCD, 1'b0, 20'h9F00E, 2'd1, 1'b0, 1'b1);
        check_idle("R10 no base no wb");
        // R8: increments per size
        run_op("R8 byte", 1'b1, 20'h00200, 1'b0, 20'h0, 2'd0, 1'b0, 1'b1);
        check_idle("R10 single cycle");
        run_op("R8 word", 1'b1, 20'h00200, 1'b0, 20'h0, 2'd1, 1'b0, 1'b1);
        run_op("R8 long", 1'b1, 20'hFFFFE, 1'b0, 20'h0, 2'd3, 1'b1, 1'b1);
        // R9: stack pointer alignment
        run_op("R9 sp byte", 1'b1, 20'h00400, 1'b1, 20'h0, 2'd0, 1'b0, 1'b1);
        run_op("R9 sp odd word", 1'b1, 20'h00401, 1'b1, 20'h0, 2'd1, 1'b0, 1'b1);
        run_op("R9 non-sp odd", 1'b1, 20'h00400, 1'b0, 20'h0, 2'd0, 1'b0, 1'b1);

        // Random operands mixing every mode
        for (int i = 0; i < 400; i++) begin
            logic [19:0] b;
            b = $urandom;
            if ($urandom_range(1, 0) == 0) b[19:16] = 4'h0;
            run_op("R3-R9 random", ($urandom_range(3, 0) != 0), b, $urandom_range(1, 0),
                   $urandom, $urandom_range(3, 0), $urandom_range(1, 0), $urandom_range(1, 0));
        end
        check_idle("R10 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule